// File: doc/BRIEF.md
# ASID-Tagged Translation Buffer with Hardware Refill

This block translates 32-bit virtual addresses for one memory port of a processor. Four ways hold 4 KB pages and are filled by hardware. A fifth way holds large pages, and its page size is chosen by a configuration input. Each entry is tagged with an 8-bit address-space identifier (ASID). A 32-bit ring-ASID register gives one ASID to each of four privilege rings. The ring of a hit is the position of the byte in that register that holds the entry's ASID. An ASID of zero marks an entry as empty.

A lookup request carries an address, an access kind (load, store or fetch) and the current ring. On a single hit, the block returns a physical address and a cache policy, or a fault cause, on the following cycle. On a miss, the block raises a page-walk request that carries the address of the page-table entry. The requester sees the block as busy until the walk answers. A good answer is written into a refill way chosen in round-robin order, and the lookup then completes from that entry. A failed walk reports the original miss.

Separate ports write an entry directly, invalidate an entry, update the ring-ASID register, and probe an address for the way that holds it.

Top module: `asid_tlb`

## Requirements
- R1: The ring-ASID register resets to 0x04030201. A write stores bits 31:8 of the written value and forces bits 7:0 to 0x01. Byte r holds the ASID of ring r.
- R2: The refill ways use 4 KB pages. With 4 entries per way, the entry index is address bits 13:12 and the tag is address bits 31:12. A hit returns the physical page ORed with address bits 11:0. The response (resp_valid_o) appears on the cycle after the request is accepted.
- R3: An entry does not hit if its ASID is 0, or if its ASID appears in no byte of the ring-ASID register. Such a lookup is a miss.
- R4: The hit ring is the byte position of the matching ASID. If the hit ring is below the current ring, the response is a privilege fault: cause 26 for loads and stores, 18 for fetches.
- R5: A hit in two or more ways returns a multi-hit cause: 25 for loads and stores, 17 for fetches.
- R6: The large-page way uses a page-size code (0..3) for pages of 1, 4, 16 or 64 MB. Its 2-bit index starts at bit 20+2×code. Its physical address keeps the address bits below the page size.
- R7: Attribute code 0..11 grants read. Bit 0 adds execute and bit 1 adds write. Bits 3:2 give the cache policy: 0 bypass, 1 write-back, 2 write-through. Code 13 grants read and write with policy 3 (isolate). All other codes grant nothing. Loads need read and stores need write. Fetches need execute, and read and write do not count for them. Denied accesses return cause 27 (load), 28 (store) or 19 (fetch). Success returns cause 0.
- R8: On a miss, walk_req_o rises on the next cycle with walk_addr_o = (PTE base OR address>>10) with bits 1:0 cleared. The request and address hold, and busy_o stays high, until walk_ack_i.
- R9: A good walk answer writes a refill entry into way (counter+1) mod 4, at the index taken from the address, and advances the counter. The entry's ring comes from answer bits 5:4, its ASID from that ring's byte, and its attribute from bits 3:0. The lookup then completes from that entry one cycle after the answer. A failed walk returns miss cause 24 (load/store) or 16 (fetch) and leaves the counter unchanged.
- R10: Invalidating an entry clears its ASID, so it no longer hits.
- R11: A probe with a single hit whose ring is at or above the probe ring returns address bits 31:12 ORed with the way number and 0x10 (data buffer) or 0x08 (instruction buffer). Any other probe returns 0.
- R12: After reset every entry has ASID 0 and the refill counter is 0, so every lookup misses and the first good refill lands in way 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request, accepted when not busy |
| req_vaddr_i | input | 32 | Lookup virtual address |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch |
| req_ring_i | input | 2 | Current privilege ring |
| busy_o | output | 1 | Refill in progress, requests ignored |
| resp_valid_o | output | 1 | Response strobe |
| resp_ok_o | output | 1 | Translation granted |
| resp_cause_o | output | 5 | Fault cause, 0 when granted |
| resp_paddr_o | output | 32 | Physical address |
| resp_cache_o | output | 2 | Cache policy |
| walk_req_o | output | 1 | Page-walk request |
| walk_addr_o | output | 32 | Page-table entry address |
| walk_ack_i | input | 1 | Walk answer strobe |
| walk_err_i | input | 1 | Walk failed |
| walk_pte_i | input | 32 | Returned page-table entry |
| ptbase_i | input | 32 | Page-table base |
| pg_code_i | input | 2 | Large-page size code |
| rasid_we_i | input | 1 | Ring-ASID register write |
| rasid_wdata_i | input | 32 | Ring-ASID write data |
| rasid_o | output | 32 | Ring-ASID register |
| wr_en_i | input | 1 | Direct entry write |
| wr_way_i | input | 3 | Target way, 0..3 refill, 4 large-page |
| wr_vaddr_i | input | 32 | Virtual address of the entry |
| wr_pte_i | input | 32 | Page-table entry to store |
| inv_en_i | input | 1 | Invalidate an entry |
| inv_way_i | input | 3 | Way to invalidate |
| inv_vaddr_i | input | 32 | Address selecting the entry |
| probe_vaddr_i | input | 32 | Probe address |
| probe_ring_i | input | 2 | Probe ring |
| probe_data_o | output | 32 | Probe result |

## Verification
The bench goes after the cases where a lookup logic can be almost right.

- A duplicate tag in two ways must produce the multi-hit cause; logic that took the first hit would return a normal translation.
- A refill must land in way 1 first. A counter read before the increment would put it in way 0, and the probe result would show that.
- The walk address must keep bits 1:0 clear. The bench uses an address whose shifted value sets those bits.
- A fetch to a read/write page must fault, and a store to a read-only large page must fault. Logic that did not mask access rights by kind would grant both.
- Rewriting the ring-ASID register must orphan the entries tagged with the old ASID, and the large-page index must follow the size code.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int VPN_W = 20;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    logic [7:0]       asid;
    logic [3:0]       attr;
  } tlb_ent_t;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [4:0] CAUSE_NONE     = 5'd0;
  localparam logic [4:0] CAUSE_I_MISS   = 5'd16;
  localparam logic [4:0] CAUSE_I_MULTI  = 5'd17;
  localparam logic [4:0] CAUSE_I_PRIV   = 5'd18;
  localparam logic [4:0] CAUSE_I_DENY   = 5'd19;
  localparam logic [4:0] CAUSE_D_MISS   = 5'd24;
  localparam logic [4:0] CAUSE_D_MULTI  = 5'd25;
  localparam logic [4:0] CAUSE_D_PRIV   = 5'd26;
  localparam logic [4:0] CAUSE_L_DENY   = 5'd27;
  localparam logic [4:0] CAUSE_S_DENY   = 5'd28;

  localparam logic [1:0] POL_BYPASS  = 2'd0;
  localparam logic [1:0] POL_WB      = 2'd1;
  localparam logic [1:0] POL_WT      = 2'd2;
  localparam logic [1:0] POL_ISOLATE = 2'd3;

  localparam logic [31:0] SMALL_MASK = 32'hFFFF_F000;

  function automatic logic [31:0] big_mask(input logic [1:0] code);
    return 32'hFFF0_0000 << {code, 1'b0};
  endfunction

  function automatic logic [1:0] big_index(input logic [31:0] va, input logic [1:0] code);
    logic [31:0] sh;
    sh = va >> (5'd20 + {2'b00, code, 1'b0});
    return sh[1:0];
  endfunction

  // {valid, ring}; lowest matching byte wins
  function automatic logic [2:0] asid_ring(input logic [7:0] asid, input logic [31:0] rasid);
    logic [2:0] res;
    res = 3'b000;
    for (int r = 3; r >= 0; r--)
      if (asid != 8'd0 && rasid[8*r +: 8] == asid) res = {1'b1, 2'(r)};
    return res;
  endfunction

  function automatic tlb_ent_t make_ent(input logic [31:0] va, input logic [31:0] pte,
                                        input logic [31:0] mask, input logic [31:0] rasid);
    tlb_ent_t e;
    logic [31:0] v, p;
    v      = va & mask;
    p      = pte & mask;
    e.vpn  = v[31:12];
    e.ppn  = p[31:12];
    e.asid = rasid[8*pte[5:4] +: 8];
    e.attr = pte[3:0];
    return e;
  endfunction
endpackage

// File: rtl/tlb_ring_reg.sv
module tlb_ring_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rasid_o
);
  logic [31:0] rasid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rasid_q <= 32'h0403_0201;
    else if (we_i) rasid_q <= (wdata_i & 32'hFFFF_FF00) | 32'h0000_0001;
  end

  assign rasid_o = rasid_q;

  AST_RASID_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rasid_o == {$past(wdata_i[31:8]), 8'h01}); // R1
endmodule

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
  import tlb_pkg::*;
(
  input  logic [3:0] attr_i,
  input  logic       fetch_i,
  output logic       rd_o,
  output logic       wr_o,
  output logic       ex_o,
  output logic [1:0] cache_o
);
  logic rd, wr, ex;

  always_comb begin
    rd = 1'b0; wr = 1'b0; ex = 1'b0; cache_o = POL_BYPASS;
    if (attr_i < 4'd12) begin
      rd = 1'b1;
      ex = attr_i[0];
      wr = attr_i[1];
      unique case (attr_i[3:2])
        2'd1:    cache_o = POL_WB;
        2'd2:    cache_o = POL_WT;
        default: cache_o = POL_BYPASS;
      endcase
    end else if (attr_i == 4'd13) begin
      rd = 1'b1; wr = 1'b1; cache_o = POL_ISOLATE;
    end
  end

  // fetches see only execute, data accesses never see it
  assign rd_o = rd & ~fetch_i;
  assign wr_o = wr & ~fetch_i;
  assign ex_o = ex & fetch_i;
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int NWAY = 4,
  parameter int NENT = 4,
  localparam int IDXW = $clog2(NENT)
) (
  input  logic [31:0] vaddr_i,
  input  logic [1:0]  pg_code_i,
  input  logic [31:0] rasid_i,
  input  tlb_ent_t    ar_i [NWAY][NENT],
  input  tlb_ent_t    big_i [4],
  output logic        hit_o,
  output logic        multi_o,
  output logic [2:0]  way_o,
  output logic [1:0]  ring_o,
  output logic [3:0]  attr_o,
  output logic [31:0] paddr_o
);
  localparam int NW = NWAY + 1;

  logic [NW-1:0] hits;
  logic [1:0]    rings [NW];
  logic [3:0]    attrs [NW];
  logic [31:0]   pas   [NW];
  logic [31:0]   bmask;

  assign bmask = big_mask(pg_code_i);

  for (genvar w = 0; w < NWAY; w++) begin : g_small
    tlb_ent_t   e;
    logic [2:0] rr;
    assign e        = ar_i[w][vaddr_i[12 +: IDXW]];
    assign rr       = asid_ring(e.asid, rasid_i);
    assign hits[w]  = rr[2] && (e.vpn == vaddr_i[31:12]);
    assign rings[w] = rr[1:0];
    assign attrs[w] = e.attr;
    assign pas[w]   = {e.ppn, vaddr_i[11:0]};
  end

  begin : g_big
    tlb_ent_t   e;
    logic [2:0] rr;
    assign e           = big_i[big_index(vaddr_i, pg_code_i)];
    assign rr          = asid_ring(e.asid, rasid_i);
    assign hits[NWAY]  = rr[2] && ((({e.vpn, 12'h000} ^ vaddr_i) & bmask) == 32'd0);
    assign rings[NWAY] = rr[1:0];
    assign attrs[NWAY] = e.attr;
    assign pas[NWAY]   = ({e.ppn, 12'h000} & bmask) | (vaddr_i & ~bmask);
  end

  always_comb begin
    way_o = 3'd0; ring_o = 2'd0; attr_o = 4'd0; paddr_o = 32'd0;
    for (int w = NW - 1; w >= 0; w--)
      if (hits[w]) begin
        way_o = 3'(w); ring_o = rings[w]; attr_o = attrs[w]; paddr_o = pas[w];
      end
  end

  assign hit_o   = |hits;
  assign multi_o = $countones(hits) > 1;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int NENT    = 4,
  parameter bit IS_DATA = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_vaddr_i,
  input  logic [1:0]  req_kind_i,
  input  logic [1:0]  req_ring_i,
  output logic        busy_o,
  output logic        resp_valid_o,
  output logic        resp_ok_o,
  output logic [4:0]  resp_cause_o,
  output logic [31:0] resp_paddr_o,
  output logic [1:0]  resp_cache_o,
  output logic        walk_req_o,
  output logic [31:0] walk_addr_o,
  input  logic        walk_ack_i,
  input  logic        walk_err_i,
  input  logic [31:0] walk_pte_i,
  input  logic [31:0] ptbase_i,
  input  logic [1:0]  pg_code_i,
  input  logic        rasid_we_i,
  input  logic [31:0] rasid_wdata_i,
  output logic [31:0] rasid_o,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_way_i,
  input  logic [31:0] wr_vaddr_i,
  input  logic [31:0] wr_pte_i,
  input  logic        inv_en_i,
  input  logic [2:0]  inv_way_i,
  input  logic [31:0] inv_vaddr_i,
  input  logic [31:0] probe_vaddr_i,
  input  logic [1:0]  probe_ring_i,
  output logic [31:0] probe_data_o
);
  localparam int NWAY = 4;
  localparam int IDXW = $clog2(NENT);
  localparam logic [31:0] PROBE_TAG = IS_DATA ? 32'h10 : 32'h08;

  typedef enum logic {ST_IDLE, ST_WALK} st_t;

  st_t         state_q;
  tlb_ent_t    ar_q  [NWAY][NENT];
  tlb_ent_t    big_q [4];
  logic [1:0]  cnt_q;
  logic [31:0] va_q;
  logic [1:0]  kind_q, ring_q;
  logic [31:0] walk_addr_q;
  logic        rv_q, rok_q;
  logic [4:0]  rcause_q;
  logic [31:0] rpa_q;
  logic [1:0]  rcache_q;
  logic [31:0] rasid;
  logic [31:0] bmask;

  tlb_ring_reg u_ring (
    .clk_i, .rst_ni, .we_i(rasid_we_i), .wdata_i(rasid_wdata_i), .rasid_o(rasid)
  );
  assign rasid_o = rasid;
  assign bmask   = big_mask(pg_code_i);

  // lookup and probe share the match structure
  logic        l_hit, l_multi;
  logic [2:0]  l_way;
  logic [1:0]  l_ring;
  logic [3:0]  l_attr;
  logic [31:0] l_pa;

  tlb_match #(.NWAY(NWAY), .NENT(NENT)) u_look (
    .vaddr_i(req_vaddr_i), .pg_code_i, .rasid_i(rasid), .ar_i(ar_q), .big_i(big_q),
    .hit_o(l_hit), .multi_o(l_multi), .way_o(l_way), .ring_o(l_ring),
    .attr_o(l_attr), .paddr_o(l_pa)
  );

  logic        p_hit, p_multi;
  logic [2:0]  p_way;
  logic [1:0]  p_ring;
  logic [3:0]  p_attr;
  logic [31:0] p_pa;

  tlb_match #(.NWAY(NWAY), .NENT(NENT)) u_probe (
    .vaddr_i(probe_vaddr_i), .pg_code_i, .rasid_i(rasid), .ar_i(ar_q), .big_i(big_q),
    .hit_o(p_hit), .multi_o(p_multi), .way_o(p_way), .ring_o(p_ring),
    .attr_o(p_attr), .paddr_o(p_pa)
  );

  logic p_unused;
  assign p_unused = ^{p_attr, p_pa, l_way};

  always_comb begin
    probe_data_o = 32'd0;
    if (p_hit && !p_multi && p_ring >= probe_ring_i)
      probe_data_o = (probe_vaddr_i & SMALL_MASK) | PROBE_TAG | {29'd0, p_way};
  end

  // shared result evaluation: lookup hit while idle, walk answer while walking
  logic        idle, acc, refill, fetch, grant, rd, wr, ex;
  logic [1:0]  kind, cur_ring, e_ring, cache;
  logic [3:0]  e_attr;
  logic [31:0] e_pa, va;
  logic [4:0]  e_cause, miss_cause, multi_cause;

  assign idle     = state_q == ST_IDLE;
  assign acc      = idle && req_valid_i;
  assign refill   = !idle && walk_ack_i && !walk_err_i;
  assign kind     = idle ? req_kind_i  : kind_q;
  assign cur_ring = idle ? req_ring_i  : ring_q;
  assign va       = idle ? req_vaddr_i : va_q;
  assign e_ring   = idle ? l_ring : walk_pte_i[5:4];
  assign e_attr   = idle ? l_attr : walk_pte_i[3:0];
  assign e_pa     = idle ? l_pa   : ((walk_pte_i & SMALL_MASK) | {20'd0, va_q[11:0]});
  assign fetch    = kind == KIND_FETCH;

  tlb_attr_decode u_attr (
    .attr_i(e_attr), .fetch_i(fetch), .rd_o(rd), .wr_o(wr), .ex_o(ex), .cache_o(cache)
  );

  always_comb begin
    unique case (kind)
      KIND_LOAD:  grant = rd;
      KIND_STORE: grant = wr;
      KIND_FETCH: grant = ex;
      default:    grant = 1'b0;
    endcase
    if (e_ring < cur_ring)
      e_cause = fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    else if (!grant)
      e_cause = fetch ? CAUSE_I_DENY : (kind == KIND_STORE ? CAUSE_S_DENY : CAUSE_L_DENY);
    else
      e_cause = CAUSE_NONE;
    miss_cause  = fetch ? CAUSE_I_MISS  : CAUSE_D_MISS;
    multi_cause = fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= 2'd0;
      va_q        <= '0;
      kind_q      <= '0;
      ring_q      <= '0;
      walk_addr_q <= '0;
      rv_q        <= 1'b0;
      rok_q       <= 1'b0;
      rcause_q    <= CAUSE_NONE;
      rpa_q       <= '0;
      rcache_q    <= '0;
    end else begin
      rv_q <= 1'b0;
      if (acc) begin
        va_q   <= req_vaddr_i;
        kind_q <= req_kind_i;
        ring_q <= req_ring_i;
        if (l_multi) begin
          rv_q <= 1'b1; rok_q <= 1'b0; rcause_q <= multi_cause;
        end else if (l_hit) begin
          rv_q <= 1'b1; rok_q <= (e_cause == CAUSE_NONE); rcause_q <= e_cause;
          rpa_q <= e_pa; rcache_q <= cache;
        end else begin
          state_q     <= ST_WALK;
          walk_addr_q <= (ptbase_i | (req_vaddr_i >> 10)) & 32'hFFFF_FFFC;
        end
      end else if (!idle && walk_ack_i) begin
        state_q <= ST_IDLE;
        rv_q    <= 1'b1;
        if (walk_err_i) begin
          rok_q <= 1'b0; rcause_q <= miss_cause;
        end else begin
          rok_q <= (e_cause == CAUSE_NONE); rcause_q <= e_cause;
          rpa_q <= e_pa; rcache_q <= cache;
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end

  // entry storage; refill is applied last so it wins a same-entry clash
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWAY; w++)
        for (int i = 0; i < NENT; i++) ar_q[w][i] <= '0;
      for (int i = 0; i < 4; i++) big_q[i] <= '0;
    end else begin
      if (wr_en_i) begin
        if (wr_way_i < 3'd4)
          ar_q[wr_way_i[1:0]][wr_vaddr_i[12 +: IDXW]] <= make_ent(wr_vaddr_i, wr_pte_i, SMALL_MASK, rasid);
        else if (wr_way_i == 3'd4)
          big_q[big_index(wr_vaddr_i, pg_code_i)] <= make_ent(wr_vaddr_i, wr_pte_i, bmask, rasid);
      end
      if (inv_en_i) begin
        if (inv_way_i < 3'd4)
          ar_q[inv_way_i[1:0]][inv_vaddr_i[12 +: IDXW]].asid <= 8'd0;
        else if (inv_way_i == 3'd4)
          big_q[big_index(inv_vaddr_i, pg_code_i)].asid <= 8'd0;
      end
      if (refill)
        ar_q[cnt_q + 2'd1][va_q[12 +: IDXW]] <= make_ent(va_q, walk_pte_i, SMALL_MASK, rasid);
    end
  end

  logic va_unused;
  assign va_unused = ^va;

  assign busy_o       = !idle;
  assign walk_req_o   = !idle;
  assign walk_addr_o  = walk_addr_q;
  assign resp_valid_o = rv_q;
  assign resp_ok_o    = rok_q;
  assign resp_cause_o = rcause_q;
  assign resp_paddr_o = rpa_q;
  assign resp_cache_o = rcache_q;

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && l_hit |=> resp_valid_o && !busy_o); // R2
  AST_MISS_STARTS_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !l_hit |=> walk_req_o && busy_o && !resp_valid_o); // R8
  AST_WALK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && !walk_ack_i |=> walk_req_o && $stable(walk_addr_o)); // R8
  AST_REFILL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && walk_ack_i |=> resp_valid_o && !walk_req_o &&
      (cnt_q == $past(cnt_q) + ($past(walk_err_i) ? 2'd0 : 2'd1))); // R9
  AST_PROBE_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_data_o != 32'd0 |-> probe_data_o[31:12] == probe_vaddr_i[31:12]); // R11
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [1:0]  ring;
    logic        ok;
    logic [4:0]  cause;
    logic [31:0] pa;
    logic [1:0]  cache;
    logic [3:0]  req;
  } vec_t;

  // R2 R4 R6 R7 vectors, applied after the entries below are written
  localparam vec_t VECS [12] = '{
    '{32'h0000_2ABC, 2'd0, 2'd0, 1'b1, 5'd0,  32'h1234_5ABC, 2'd1, 4'd2},
    '{32'h0000_2ABC, 2'd1, 2'd0, 1'b1, 5'd0,  32'h1234_5ABC, 2'd1, 4'd7},
    '{32'h0000_2ABC, 2'd2, 2'd0, 1'b1, 5'd0,  32'h1234_5ABC, 2'd1, 4'd7},
    '{32'h0000_3010, 2'd0, 2'd2, 1'b1, 5'd0,  32'h2222_2010, 2'd0, 4'd4},
    '{32'h0000_3010, 2'd0, 2'd3, 1'b0, 5'd26, 32'h0,         2'd0, 4'd4},
    '{32'h0000_3010, 2'd2, 2'd3, 1'b0, 5'd18, 32'h0,         2'd0, 4'd4},
    '{32'h0000_3010, 2'd1, 2'd0, 1'b0, 5'd28, 32'h0,         2'd0, 4'd7},
    '{32'h0000_5444, 2'd1, 2'd1, 1'b1, 5'd0,  32'h3333_3444, 2'd3, 4'd7},
    '{32'h0000_5444, 2'd2, 2'd0, 1'b0, 5'd19, 32'h0,         2'd0, 4'd7},
    '{32'h0000_7000, 2'd0, 2'd0, 1'b0, 5'd27, 32'h0,         2'd0, 4'd7},
    '{32'hC051_2345, 2'd0, 2'd0, 1'b1, 5'd0,  32'h8A11_2345, 2'd1, 4'd6},
    '{32'hC051_2345, 2'd1, 2'd0, 1'b0, 5'd28, 32'h0,         2'd0, 4'd6}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0, req_ring = '0;
  logic        busy, resp_valid, resp_ok, walk_req;
  logic [4:0]  resp_cause;
  logic [31:0] resp_paddr, walk_addr, rasid, probe_data;
  logic [1:0]  resp_cache;
  logic        walk_ack = 1'b0, walk_err = 1'b0;
  logic [31:0] walk_pte = '0;
  logic [31:0] ptbase = 32'h8000_0000;
  logic [1:0]  pg_code = 2'd1;
  logic        rasid_we = 1'b0;
  logic [31:0] rasid_wdata = '0;
  logic        wr_en = 1'b0, inv_en = 1'b0;
  logic [2:0]  wr_way = '0, inv_way = '0;
  logic [31:0] wr_vaddr = '0, wr_pte = '0, inv_vaddr = '0, probe_vaddr = '0;
  logic [1:0]  probe_ring = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  asid_tlb u_asid_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_kind_i(req_kind), .req_ring_i(req_ring),
    .busy_o(busy), .resp_valid_o(resp_valid), .resp_ok_o(resp_ok), .resp_cause_o(resp_cause),
    .resp_paddr_o(resp_paddr), .resp_cache_o(resp_cache),
    .walk_req_o(walk_req), .walk_addr_o(walk_addr), .walk_ack_i(walk_ack), .walk_err_i(walk_err),
    .walk_pte_i(walk_pte), .ptbase_i(ptbase), .pg_code_i(pg_code),
    .rasid_we_i(rasid_we), .rasid_wdata_i(rasid_wdata), .rasid_o(rasid),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_vaddr_i(wr_vaddr), .wr_pte_i(wr_pte),
    .inv_en_i(inv_en), .inv_way_i(inv_way), .inv_vaddr_i(inv_vaddr),
    .probe_vaddr_i(probe_vaddr), .probe_ring_i(probe_ring), .probe_data_o(probe_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic write_ent(input logic [2:0] way, input logic [31:0] va, input logic [31:0] pte);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_vaddr = va; wr_pte = pte;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic inval(input logic [2:0] way, input logic [31:0] va);
    @(negedge clk);
    inv_en = 1'b1; inv_way = way; inv_vaddr = va;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic set_rasid(input logic [31:0] v);
    @(negedge clk);
    rasid_we = 1'b1; rasid_wdata = v;
    @(negedge clk);
    rasid_we = 1'b0;
  endtask

  // drives one request; returns at the negedge after the accepting edge
  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] ring);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_ring = ring;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic walk_reply(input logic err, input logic [31:0] pte);
    walk_ack = 1'b1; walk_err = err; walk_pte = pte;
    @(negedge clk);
    walk_ack = 1'b0; walk_err = 1'b0;
  endtask

  task automatic probe(input logic [31:0] va, input logic [1:0] ring);
    @(negedge clk);
    probe_vaddr = va; probe_ring = ring;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R12 reset state
    check("R1 rasid reset", rasid, 32'h0403_0201);
    check("R12 idle after reset", {29'd0, busy, resp_valid, walk_req}, 32'd0);
    probe(32'h0000_1000, 2'd0);
    check("R12 probe empty", probe_data, 32'd0);
    lookup(32'h0000_1000, 2'd0, 2'd0);
    check("R12 reset miss walk req", {31'd0, walk_req & busy}, 32'd1);
    check("R8 walk address", walk_addr, 32'h8000_0004);
    walk_reply(1'b1, 32'd0);
    check("R9 failed walk valid", {31'd0, resp_valid}, 32'd1);
    check("R9 failed walk cause", {27'd0, resp_cause}, 32'd24);

    // R1 ring-ASID write forces byte 0
    set_rasid(32'h3020_10FF);
    check("R1 rasid write", rasid, 32'h3020_1001);

    write_ent(3'd0, 32'h0000_2000, 32'h1234_5007);
    write_ent(3'd1, 32'h0000_3000, 32'h2222_2021);
    write_ent(3'd2, 32'h0000_5000, 32'h3333_301D);
    write_ent(3'd3, 32'h0000_7000, 32'h4444_403F);
    write_ent(3'd4, 32'hC040_0000, 32'h8A00_0004);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      string tag = $sformatf("R%0d vec %0d", v.req, i);
      lookup(v.va, v.kind, v.ring);
      check({tag, " valid"}, {31'd0, resp_valid}, 32'd1);
      check({tag, " ok"}, {31'd0, resp_ok}, {31'd0, v.ok});
      check({tag, " cause"}, {27'd0, resp_cause}, {27'd0, v.cause});
      if (v.ok) begin
        check({tag, " paddr"}, resp_paddr, v.pa);
        check({tag, " cache"}, {30'd0, resp_cache}, {30'd0, v.cache});
      end
    end

    // R5 duplicate tag in way 3
    write_ent(3'd3, 32'h0000_2000, 32'h6666_6007);
    lookup(32'h0000_2ABC, 2'd0, 2'd0);
    check("R5 multi data", {27'd0, resp_cause}, 32'd25);
    lookup(32'h0000_2ABC, 2'd2, 2'd0);
    check("R5 multi fetch", {27'd0, resp_cause}, 32'd17);

    // R10 invalidate removes the duplicate
    inval(3'd3, 32'h0000_2000);
    lookup(32'h0000_2ABC, 2'd0, 2'd0);
    check("R10 single hit after inval", resp_paddr, 32'h1234_5ABC);
    inval(3'd0, 32'h0000_2000);
    lookup(32'h0000_2ABC, 2'd0, 2'd0);
    check("R10 inval gives miss", {31'd0, walk_req}, 32'd1);
    check("R8 walk address low bits", walk_addr, 32'h8000_0008);
    @(negedge clk);
    check("R8 busy held", {30'd0, busy, walk_req}, 32'd3);
    check("R8 address held", walk_addr, 32'h8000_0008);
    walk_reply(1'b0, 32'h7777_7017);
    check("R9 refill ok", {31'd0, resp_ok & resp_valid}, 32'd1);
    check("R9 refill paddr", resp_paddr, 32'h7777_7ABC);
    check("R9 refill cache", {30'd0, resp_cache}, 32'd1);
    probe(32'h0000_2ABC, 2'd0);
    check("R9 first refill in way 1", probe_data, 32'h0000_2011);
    probe(32'h0000_2ABC, 2'd2);
    check("R11 probe below ring", probe_data, 32'd0);
    lookup(32'h0000_2ABC, 2'd0, 2'd2);
    check("R9 refill ring from pte", {27'd0, resp_cause}, 32'd26);

    inval(3'd1, 32'h0000_2000);
    lookup(32'h0000_2ABC, 2'd0, 2'd0);
    walk_reply(1'b0, 32'h7777_7017);
    probe(32'h0000_2ABC, 2'd1);
    check("R9 second refill in way 2", probe_data, 32'h0000_2012);
    probe(32'h0000_9000, 2'd0);
    check("R11 probe miss", probe_data, 32'd0);

    // R6 16 MB pages
    @(negedge clk);
    pg_code = 2'd2;
    write_ent(3'd4, 32'h2100_0000, 32'h5500_0004);
    lookup(32'h21AB_CDEF, 2'd0, 2'd0);
    check("R6 code 2 valid", {30'd0, resp_valid, resp_ok}, 32'd3);
    check("R6 code 2 paddr", resp_paddr, 32'h55AB_CDEF);

    // R3 ASID no longer in any ring byte
    set_rasid(32'h3050_1000);
    check("R1 rasid rewrite", rasid, 32'h3050_1001);
    lookup(32'h0000_3010, 2'd0, 2'd0);
    check("R3 orphan asid misses", {31'd0, walk_req}, 32'd1);
    walk_reply(1'b1, 32'd0);
    check("R3 miss cause", {27'd0, resp_cause}, 32'd24);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule